// File: doc/BRIEF.md
# SPI Master Frame Engine

This block is a serial master that moves one word at a time over a four-wire synchronous link. Software-side logic pushes words into a small transmit queue. While the engine is enabled and that queue holds data, the engine lowers the active-low select line, clocks the frame out on the data-out line, and samples the data-in line. Each received word goes into a receive queue. Clock polarity and clock phase follow the usual four-mode convention. The frame length can be set anywhere from 4 to 16 bits, and the serial clock rate comes from a programmable divider of the system clock.

Once a frame ends, the engine checks the transmit queue. If another word is waiting and the engine is still enabled, the next frame follows with select held low. If not, select is released half a serial period later and the lines go back to their idle levels. While idle, the data-out driver enable is low, so the pad can be left floating.

Top module: `spi_frame_master`

## Requirements
- R1: While no frame is in progress, selN is 1, mosiOe is 0 and sck equals cpol. After reset, both queues report empty and rxOverrun is 0.
- R2: A frame starts only when enable is 1 and the transmit queue is not empty. The start lowers selN and raises mosiOe in the same cycle. With enable at 0, queued words stay unsent.
- R3: One serial half-period is D system cycles, where D is clkDiv, or 1 when clkDiv is 0. The first sck edge of a frame comes 2·D cycles after selN falls, and every later edge of the frame comes D cycles after the one before. With cpha 0, the first data bit is on mosi D cycles before the first edge.
- R4: With cpha 0, mosi is sampled on odd-numbered edges of a frame and changes on even-numbered ones. With cpha 1 this is reversed. With cpol 1, the sck waveform is the inverse of the cpol 0 waveform.
- R5: The frame length N is frameLen clamped to the range 4..16. Each frame has exactly 2·N sck edges and carries bits N-1 down to 0 of the transmit word, most significant first, on both mosi and miso.
- R6: After the last edge of a frame, a waiting word (with enable at 1) starts its next frame without releasing selN. That next frame again takes 2·D cycles to its first edge. Otherwise selN rises D cycles after the last edge.
- R7: Each received frame is stored right-aligned in bit 0 and up, with zeros above bit N-1.
- R8: A received frame that arrives while the receive queue is full is discarded, and rxOverrun is set and stays set until reset.
- R9: Each queue holds 8 words and reports full and empty. A write to a full transmit queue is ignored.
- R10: rxData shows the oldest received word, and rxRead removes it, so words leave in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows frames to start |
| cpol | input | 1 | Idle level of sck |
| cpha | input | 1 | 0: sample on first edge; 1: sample on second edge |
| frameLen | input | 5 | Frame length in bits, clamped to 4..16 |
| clkDiv | input | 8 | System cycles per sck half-period (0 acts as 1) |
| txData | input | 16 | Word to queue for transmission |
| txWrite | input | 1 | Pushes txData into the transmit queue |
| txFull | output | 1 | Transmit queue full |
| txEmpty | output | 1 | Transmit queue empty |
| rxData | output | 16 | Oldest received word |
| rxRead | input | 1 | Removes the oldest received word |
| rxEmpty | output | 1 | Receive queue empty |
| rxFull | output | 1 | Receive queue full |
| rxOverrun | output | 1 | Sticky flag: a received word was discarded |
| sck | output | 1 | Serial clock |
| selN | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data out |
| mosiOe | output | 1 | Driver enable for mosi |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the block with its default parameters: 16-bit words, queues 8 deep and an 8-bit divider. The divider sweep includes 0, 1 and 3, which covers the zero-means-one rule and the fastest setting. Queues 8 deep let a short burst fill the transmit queue, drive the receive queue into overrun, and keep select low across a chain of eight frames. The sweep covers all four polarity/phase modes at lengths 4, 5, 8, 12 and 16, plus two out-of-range lengths. A line monitor measures every edge spacing in system cycles and rebuilds each transmitted word from mosi. A slave that returns the inverse of mosi makes every received value predictable.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEL,
    ST_SHIFT,
    ST_TAIL
  } ctrlState_t;

  typedef struct packed {
    logic load;
    logic toggle;
    logic sample;
    logic launch;
    logic done;
  } spiStrobe_t;

endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic wrOk, rdOk;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign wrOk  = wr && !full;
  assign rdOk  = rd && !empty;
  assign rdata = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (wrOk) mem[wrPtr] <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (wrOk) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (rdOk) rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({wrOk, rdOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R9: occupancy never exceeds the depth
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));

  // R9: a write into a full queue leaves it unchanged
  a_r9_full_ignores_write: assert property (@(posedge clk) disable iff (!rstN)
    (full && wr && !rd) |=> (full && $stable(wrPtr)));

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_frame_pkg::*;
#(
  parameter int W       = 16,
  parameter int MIN_LEN = 4,
  parameter int DIV_W   = 8,
  parameter int LEN_W   = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             cpha,
  input  logic [LEN_W-1:0] frameLen,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic             txEmpty,
  output logic             selN,
  output logic             mosiOe,
  output logic             txPop,
  output logic [LEN_W-1:0] effLen,
  output spiStrobe_t       stb
);
  localparam int EC_W = LEN_W + 1;

  ctrlState_t state;
  logic [DIV_W-1:0] divCnt, divEff;
  logic [EC_W-1:0] edgeCnt, edgeNext, edgeLast;
  logic tick, more, sampleEdge;

  always_comb begin
    if (frameLen < LEN_W'(MIN_LEN))  effLen = LEN_W'(MIN_LEN);
    else if (frameLen > LEN_W'(W))   effLen = LEN_W'(W);
    else                             effLen = frameLen;
  end

  assign divEff     = (clkDiv == '0) ? DIV_W'(1) : clkDiv;
  assign tick       = (state != ST_IDLE) && (divCnt == divEff - 1'b1);
  assign edgeNext   = edgeCnt + 1'b1;
  assign edgeLast   = {effLen, 1'b0};
  assign more       = enable && !txEmpty;
  assign sampleEdge = edgeNext[0] ^ cpha;

  always_comb begin
    stb.load   = (state == ST_SEL) && tick;
    stb.toggle = (state == ST_SHIFT) && tick;
    stb.sample = stb.toggle && sampleEdge;
    stb.launch = stb.toggle && !sampleEdge;
    stb.done   = stb.toggle && (edgeNext == edgeLast);
  end

  assign txPop = stb.load;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      selN    <= 1'b1;
      mosiOe  <= 1'b0;
      divCnt  <= '0;
      edgeCnt <= '0;
    end else begin
      divCnt <= (state == ST_IDLE || tick) ? '0 : divCnt + 1'b1;
      case (state)
        ST_IDLE: if (more) begin
          selN   <= 1'b0;
          mosiOe <= 1'b1;
          state  <= ST_SEL;
        end
        ST_SEL: if (tick) begin
          edgeCnt <= '0;
          state   <= ST_SHIFT;
        end
        ST_SHIFT: if (tick) begin
          edgeCnt <= edgeNext;
          if (stb.done) state <= more ? ST_SEL : ST_TAIL;
        end
        default: if (tick) begin
          selN   <= 1'b1;
          mosiOe <= 1'b0;
          state  <= ST_IDLE;
        end
      endcase
    end
  end

  // R2: select only falls after an enabled, non-empty queue was seen
  a_r2_start_gated: assert property (@(posedge clk) disable iff (!rstN)
    $fell(selN) |-> $past(enable && !txEmpty));

  // R2: a word is only taken from a non-empty queue
  a_r2_load_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |-> !txEmpty);

  // R5: the edge counter stays below 2N while shifting
  a_r5_edge_range: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SHIFT) |-> (edgeCnt < edgeLast));

  // R6: select stays low for the whole frame sequence
  a_r6_sel_low_busy: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> (!selN && mosiOe));

endmodule

// File: rtl/spi_frame_datapath.sv
module spi_frame_datapath
  import spi_frame_pkg::*;
#(
  parameter int W     = 16,
  parameter int LEN_W = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  spiStrobe_t       stb,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [LEN_W-1:0] effLen,
  input  logic [W-1:0]     txWord,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic [W-1:0]     rxWord,
  output logic             rxPush
);
  logic [W-1:0] txShift, rxShift, aligned;
  logic sckInt, mosiReg;

  assign aligned = txWord << (LEN_W'(W) - effLen);
  assign sck     = sckInt ^ cpol;
  assign mosi    = mosiReg;
  assign rxWord  = rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      sckInt  <= 1'b0;
      mosiReg <= 1'b0;
      rxPush  <= 1'b0;
    end else begin
      rxPush <= stb.done;
      if (stb.toggle) sckInt <= !sckInt;
      if (stb.load) begin
        rxShift <= '0;
        if (cpha) begin
          txShift <= aligned;
          mosiReg <= 1'b0;
        end else begin
          txShift <= aligned << 1;
          mosiReg <= aligned[W-1];
        end
      end
      if (stb.launch) begin
        mosiReg <= txShift[W-1];
        txShift <= txShift << 1;
      end
      if (stb.sample) rxShift <= {rxShift[W-2:0], miso};
    end
  end

  // R7: a pushed word carries nothing above bit N-1
  a_r7_zero_ext: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |-> ((rxShift >> effLen) == '0));

  // R5: after the last edge the clock is back at its idle phase
  a_r5_sck_home: assert property (@(posedge clk) disable iff (!rstN)
    stb.done |=> (sckInt == 1'b0));

endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
  import spi_frame_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int MIN_LEN    = 4,
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_W      = 8,
  parameter int LEN_W      = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic [DATA_W-1:0] txData,
  input  logic              txWrite,
  output logic              txFull,
  output logic              txEmpty,
  output logic [DATA_W-1:0] rxData,
  input  logic              rxRead,
  output logic              rxEmpty,
  output logic              rxFull,
  output logic              rxOverrun,
  output logic              sck,
  output logic              selN,
  output logic              mosi,
  output logic              mosiOe,
  input  logic              miso
);
  spiStrobe_t stb;
  logic txPop, rxPush, rxWr;
  logic [LEN_W-1:0] effLen;
  logic [DATA_W-1:0] txWord, rxWord;

  spi_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) txq_i (
    .clk(clk), .rstN(rstN), .wr(txWrite), .wdata(txData),
    .rd(txPop), .rdata(txWord), .full(txFull), .empty(txEmpty));

  spi_frame_ctrl #(.W(DATA_W), .MIN_LEN(MIN_LEN), .DIV_W(DIV_W), .LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .cpha(cpha),
    .frameLen(frameLen), .clkDiv(clkDiv), .txEmpty(txEmpty),
    .selN(selN), .mosiOe(mosiOe), .txPop(txPop), .effLen(effLen), .stb(stb));

  spi_frame_datapath #(.W(DATA_W), .LEN_W(LEN_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .cpol(cpol), .cpha(cpha),
    .effLen(effLen), .txWord(txWord), .miso(miso), .sck(sck),
    .mosi(mosi), .rxWord(rxWord), .rxPush(rxPush));

  assign rxWr = rxPush && !rxFull;

  spi_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) rxq_i (
    .clk(clk), .rstN(rstN), .wr(rxWr), .wdata(rxWord),
    .rd(rxRead), .rdata(rxData), .full(rxFull), .empty(rxEmpty));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 rxOverrun <= 1'b0;
    else if (rxPush && rxFull) rxOverrun <= 1'b1;
  end

  // R1: idle lines sit at their rest levels
  a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rstN)
    selN |-> ((sck == cpol) && !mosiOe));

  // R8: the overrun flag never clears on its own
  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    rxOverrun |=> rxOverrun);

endmodule

// File: tb/spi_frame_master_tb.sv
module spi_frame_master_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, cpol = 1'b0, cpha = 1'b0;
  logic [4:0] frameLen = 5'd8;
  logic [7:0] clkDiv = 8'd1;
  logic [15:0] txData = '0;
  logic txWrite = 1'b0, rxRead = 1'b0;
  logic txFull, txEmpty, rxEmpty, rxFull, rxOverrun, sck, selN, mosi, mosiOe, miso;
  logic [15:0] rxData;

  int nChecks = 0, nFail = 0;
  int cyc = 0, tLast = 0, fe = 0, selFalls = 0, monCnt = 0;
  logic [15:0] monWord = '0;
  logic [15:0] monQ [128];
  logic prevSel = 1'b1, prevSck = 1'b0, earlyMosi = 1'b0;

  always #2.5 clk = !clk;

  assign miso = !mosi;

  spi_frame_master dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .cpol(cpol), .cpha(cpha),
    .frameLen(frameLen), .clkDiv(clkDiv), .txData(txData), .txWrite(txWrite),
    .txFull(txFull), .txEmpty(txEmpty), .rxData(rxData), .rxRead(rxRead),
    .rxEmpty(rxEmpty), .rxFull(rxFull), .rxOverrun(rxOverrun), .sck(sck),
    .selN(selN), .mosi(mosi), .mosiOe(mosiOe), .miso(miso));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int dOf(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int nOf(input int v);
    return (v < 4) ? 4 : (v > 16) ? 16 : v;
  endfunction

  function automatic logic [15:0] maskOf(input int n);
    return 16'((32'h1 << n) - 1);
  endfunction

  // line monitor: edge spacing, early MSB, word rebuilt from mosi
  always @(negedge clk) begin
    if (!rstN) begin
      prevSel = 1'b1;
      prevSck = sck;
      fe = 0;
    end else begin
      cyc++;
      if (prevSel && !selN) begin
        selFalls++;
        tLast = cyc;
        fe = 0;
        monWord = '0;
        chk(mosiOe == 1'b1, "R2 driver on at select", int'(mosiOe), 1);
      end
      if (!selN && fe == 0 && cyc == tLast + dOf(clkDiv)) earlyMosi = mosi;
      if (!selN && sck != prevSck) begin
        fe++;
        chk(cyc - tLast == ((fe == 1) ? 2 * dOf(clkDiv) : dOf(clkDiv)),
            "R3 edge spacing", cyc - tLast, (fe == 1) ? 2 * dOf(clkDiv) : dOf(clkDiv));
        tLast = cyc;
        if (fe == 1 && !cpha)
          chk(mosi == earlyMosi, "R3 first bit half period early", int'(mosi), int'(earlyMosi));
        if ((sck ^ cpol) ^ cpha) monWord = {monWord[14:0], mosi};
        if (fe == 2 * nOf(frameLen)) begin
          monQ[monCnt] = monWord;
          monCnt++;
          fe = 0;
        end
      end
      if (!prevSel && selN) begin
        chk(cyc - tLast == dOf(clkDiv), "R6 select release delay", cyc - tLast, dOf(clkDiv));
        chk(!mosiOe && sck == cpol, "R1 idle lines after frame", int'({mosiOe, sck}), int'(cpol));
        chk(fe == 0, "R5 edge count per frame", fe, 0);
      end
      prevSel = selN;
      prevSck = sck;
    end
  end

  task automatic pushWord(input logic [15:0] w);
    @(negedge clk);
    txData = w;
    txWrite = 1'b1;
    @(negedge clk);
    txWrite = 1'b0;
  endtask

  task automatic popWord();
    @(negedge clk);
    rxRead = 1'b1;
    @(negedge clk);
    rxRead = 1'b0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 5000 && selN; i++) @(negedge clk);
    for (int i = 0; i < 20000 && !selN; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic oneFrame(input logic [15:0] w, input string req);
    int base, n;
    base = monCnt;
    n = nOf(frameLen);
    pushWord(w);
    waitDone();
    chk(monCnt == base + 1, {req, " one frame seen"}, monCnt - base, 1);
    chk(monQ[base] == (w & maskOf(n)), {req, " mosi word MSB first"}, monQ[base], w & maskOf(n));
    chk(!rxEmpty, {req, " word received"}, int'(rxEmpty), 0);
    chk(rxData == (~w & maskOf(n)), {req, " rx right-aligned zero-extended R7"},
        rxData, ~w & maskOf(n));
    popWord();
  endtask

  initial begin
    int lens[5] = '{4, 5, 8, 12, 16};
    int divs[3] = '{0, 1, 3};
    int k, base, falls;
    logic [15:0] w;
    repeat (3) @(negedge clk);
    chk(selN && !mosiOe && sck == 1'b0, "R1 reset idle lines", int'({selN, mosiOe, sck}), 4);
    chk(txEmpty && rxEmpty && !txFull && !rxFull && !rxOverrun, "R1 reset flags",
        int'({txEmpty, rxEmpty, txFull, rxFull, rxOverrun}), 5'b11000);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    enable = 1'b1;

    // R4 R5 R3: sweep modes, lengths and dividers
    k = 0;
    for (int m = 0; m < 4; m++) begin
      for (int li = 0; li < 5; li++) begin
        for (int di = 0; di < 3; di++) begin
          @(negedge clk);
          cpol = m[1];
          cpha = m[0];
          frameLen = 5'(lens[li]);
          clkDiv = 8'(divs[di]);
          @(negedge clk);
          chk(sck == cpol, "R4 idle level follows polarity", int'(sck), int'(cpol));
          w = 16'hA5C3 ^ 16'(k * 16'h1357);
          oneFrame(w, "R4 R5 sweep");
          k++;
        end
      end
    end

    // R5: out-of-range lengths clamp
    @(negedge clk); cpol = 0; cpha = 0; clkDiv = 8'd2; frameLen = 5'd2;
    oneFrame(16'hFFF6, "R5 clamp low");
    @(negedge clk); frameLen = 5'd20;
    oneFrame(16'h9E37, "R5 clamp high");

    // R2 R9: gated start and full transmit queue
    @(negedge clk); enable = 1'b0; cpol = 1; cpha = 1; clkDiv = 8'd1; frameLen = 5'd8;
    base = monCnt;
    for (int i = 0; i < 9; i++) pushWord(16'(16'h30 + i * 7));
    repeat (40) @(negedge clk);
    chk(selN && monCnt == base, "R2 no start while disabled", monCnt - base, 0);
    chk(txFull, "R9 transmit queue full after 8", int'(txFull), 1);
    falls = selFalls;
    @(negedge clk); enable = 1'b1;
    waitDone();
    chk(selFalls == falls + 1, "R6 select held across chain", selFalls - falls, 1);
    chk(monCnt == base + 8, "R9 ninth write ignored", monCnt - base, 8);
    chk(rxFull && !rxOverrun, "R9 receive queue full no overrun", int'({rxFull, rxOverrun}), 2);

    // R8: two more frames are dropped
    pushWord(16'h00AA);
    pushWord(16'h0055);
    waitDone();
    chk(monCnt == base + 10, "R8 extra frames sent", monCnt - base, 10);
    chk(rxOverrun, "R8 overrun set", int'(rxOverrun), 1);

    // R10: oldest first, dropped frames absent
    for (int i = 0; i < 8; i++) begin
      chk(rxData == 16'(~(16'h30 + i * 7) & 16'h00FF), "R10 arrival order",
          rxData, ~(16'h30 + i * 7) & 16'h00FF);
      popWord();
    end
    chk(rxEmpty && rxOverrun, "R8 dropped words absent and flag kept",
        int'({rxEmpty, rxOverrun}), 3);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule